// File: doc/BRIEF.md
# Protected Reference Clock Divider

This block is the reference front end of an on-chip PLL. It selects what the PLL sees as its reference: either the oscillator clock divided by a programmable integer, or a fixed internal 1 MHz clock. It also supplies a 2-bit loop-filter range code that tunes the PLL for the reference frequency in use. Both settings sit in one 8-bit configuration register on a small register bus made of an address, a write strobe, write data and read data.

Writes to the register are guarded. A write is accepted only when the protection input is clear and the PLL-select input is set. Every accepted write clears the PLL-lock and oscillator-ready status flags, because the reference is about to change. Outside agents set these flags with one-cycle set pulses. The divider takes up a new ratio only at the end of the output period in progress, so a reprogram never produces a runt pulse on the reference.

The block is clocked by the oscillator clock `clk_i`. The register, the divider and the flags all run in that domain.

Top module: `refdiv_top`

## Requirements
- R1: An active-low asynchronous reset, applied without any clock edge, sets the register to 0x0F (filter field 00, N=15) and clears both status flags.
- R2: A read at the register address returns {2'b00, filter[1:0], N[3:0]}, so bits 7:6 always read 0. A read at any other address returns 0x00.
- R3: A write is accepted only when `we_i`=1, `addr_i` matches the register address, `prot_i`=0 and `pll_sel_i`=1. Any other write leaves the register unchanged. An accepted write stores wdata[5:0] on the next clock edge.
- R4: An accepted write clears `lock_o` and `osc_rdy_o` on the same edge. A rejected write leaves them unchanged.
- R5: A one-cycle set pulse sets its flag on the next edge. If a set pulse and an accepted write fall in the same cycle, the flag ends up 0.
- R6: With `osc_en_i`=1 and N>0, `ref_clk_o` has a period of N+1 oscillator cycles. It is high for floor((N+1)/2) of those cycles, then low for the rest, so an even N+1 gives a 50% duty cycle.
- R7: With `osc_en_i`=1 and an active N of 0, `ref_clk_o` is the oscillator clock itself.
- R8: A new N takes effect only at the boundary where the current output period ends. The period in progress completes with its old shape.
- R9: With `osc_en_i`=0, `ref_clk_o` follows `irc_clk_i` and the divider has no effect on it.
- R10: `filt_rng_o` equals the stored filter field when `osc_en_i`=1. The codes are 00 for 1–2 MHz, 01 for above 2 up to 6 MHz, 10 for above 6 up to 12 MHz, and 11 for above 12 MHz. When `osc_en_i`=0 the output is forced to 00, while the stored field stays writable and readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock; clocks all state and is the divider source |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irc_clk_i | input | 1 | Internal 1 MHz clock |
| osc_en_i | input | 1 | 1 selects the divided oscillator, 0 selects the internal clock |
| prot_i | input | 1 | Write protection; 1 blocks writes |
| pll_sel_i | input | 1 | PLL-select mode; writes need it at 1 |
| addr_i | input | ADDR_W | Register bus address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from the address |
| lock_set_i | input | 1 | One-cycle set pulse for the lock flag |
| osc_rdy_set_i | input | 1 | One-cycle set pulse for the oscillator-ready flag |
| lock_o | output | 1 | PLL-lock status flag |
| osc_rdy_o | output | 1 | Oscillator-ready status flag |
| ref_clk_o | output | 1 | Reference clock to the PLL |
| filt_rng_o | output | 2 | Loop-filter range code to the PLL |

## Verification
A gating fault in the write path shows up on `rdata_o` and on both flags one edge after the offending write, because a protected or out-of-mode write either changes the read value or drops the flags. A wrong count or wrong half-period in the divider changes where `ref_clk_o` falls and rises within the first full period after sync, so the bench checks every cycle of whole periods for even, odd and unity ratios. A reload taken at the wrong moment leaves a shortened or stretched period right after a mid-period reprogram, and that is visible within N+1 cycles of the write.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 4;
  localparam int FILT_W = 2;

  typedef struct packed {
    logic [FILT_W-1:0] filt;
    logic [DIV_W-1:0]  n;
  } cfg_t;

  localparam int   CFG_W   = $bits(cfg_t);
  localparam cfg_t CFG_RST = '{filt: '0, n: '1};
endpackage

// File: rtl/refdiv_cfg.sv
module refdiv_cfg
  import refdiv_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(5)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              prot_i,
  input  logic              pll_sel_i,
  output cfg_t              cfg_o,
  output logic              wr_acc_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic hit;
  cfg_t cfg_q;
  logic unused_wdata;

  assign hit          = (addr_i == REG_ADDR);
  assign wr_acc_o     = we_i & hit & ~prot_i & pll_sel_i;
  assign unused_wdata = ^wdata_i[DATA_W-1:CFG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= CFG_RST;
    else if (wr_acc_o) cfg_q <= cfg_t'(wdata_i[CFG_W-1:0]);
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = hit ? DATA_W'(cfg_q) : '0;
endmodule

// File: rtl/refdiv_status.sv
module refdiv_status #(
  parameter int NUM = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic [NUM-1:0] set_i,
  output logic [NUM-1:0] flag_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[g] <= 1'b0;
      else if (clr_i)    flag_o[g] <= 1'b0;  // clear beats set
      else if (set_i[g]) flag_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/refdiv_divider.sv
module refdiv_divider #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] n_i,
  output logic             div_o,
  output logic [DIV_W-1:0] act_n_o,
  output logic             wrap_o
);
  localparam logic [DIV_W-1:0] HALF_RST = DIV_W'(1) << (DIV_W - 1);

  logic [DIV_W-1:0] cnt_q, last_q, half_q;
  logic [DIV_W-1:0] cnt_nxt, last_nxt, half_nxt;
  logic [DIV_W:0]   p_len;
  logic             out_q;

  assign wrap_o = (cnt_q == last_q);
  assign p_len  = {1'b0, n_i} + 1'b1;

  always_comb begin
    if (wrap_o) begin
      // period boundary: take up the programmed ratio
      cnt_nxt  = '0;
      last_nxt = n_i;
      half_nxt = p_len[DIV_W:1];
    end else begin
      cnt_nxt  = cnt_q + 1'b1;
      last_nxt = last_q;
      half_nxt = half_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= '1;
      half_q <= HALF_RST;
      out_q  <= 1'b1;
    end else begin
      cnt_q  <= cnt_nxt;
      last_q <= last_nxt;
      half_q <= half_nxt;
      out_q  <= (cnt_nxt < half_nxt);
    end
  end

  assign div_o   = out_q;
  assign act_n_o = last_q;
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(5)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irc_clk_i,
  input  logic              osc_en_i,
  input  logic              prot_i,
  input  logic              pll_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              lock_set_i,
  input  logic              osc_rdy_set_i,
  output logic              lock_o,
  output logic              osc_rdy_o,
  output logic              ref_clk_o,
  output logic [1:0]        filt_rng_o
);
  cfg_t             cfg_q;
  logic             wr_acc;
  logic [1:0]       flags;
  logic             div_clk;
  logic [DIV_W-1:0] act_n;
  logic             div_wrap;
  logic             osc_ref;

  refdiv_cfg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .prot_i   (prot_i),
    .pll_sel_i(pll_sel_i),
    .cfg_o    (cfg_q),
    .wr_acc_o (wr_acc),
    .rdata_o  (rdata_o)
  );

  refdiv_status #(.NUM(2)) i_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (wr_acc),
    .set_i ({osc_rdy_set_i, lock_set_i}),
    .flag_o(flags)
  );

  refdiv_divider #(.DIV_W(DIV_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .n_i    (cfg_q.n),
    .div_o  (div_clk),
    .act_n_o(act_n),
    .wrap_o (div_wrap)
  );

  assign lock_o     = flags[0];
  assign osc_rdy_o  = flags[1];
  // unity ratio bypasses the counter
  assign osc_ref    = (act_n == '0) ? clk_i : div_clk;
  assign ref_clk_o  = osc_en_i ? osc_ref : irc_clk_i;
  assign filt_rng_o = osc_en_i ? cfg_q.filt : '0;
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(5)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              prot_i,
  input logic              pll_sel_i,
  input logic              lock_set_i,
  input logic              osc_rdy_set_i,
  input logic              osc_en_i,
  input logic              irc_clk_i,
  input logic              ref_clk_o,
  input logic              lock_o,
  input logic              osc_rdy_o,
  input logic [1:0]        filt_rng_o,
  input logic [7:0]        rdata_o,
  input logic [5:0]        cfg_q,
  input logic [3:0]        act_n,
  input logic              div_wrap
);
  logic acc;
  assign acc = we_i && (addr_i == REG_ADDR) && !prot_i && pll_sel_i;

  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[7:6] == 2'b00);

  // R3
  no_blocked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> $stable(cfg_q));

  // R4
  write_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (!lock_o && !osc_rdy_o));

  // R5
  lock_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_set_i && !acc) |=> lock_o);

  // R5
  osc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_rdy_set_i && !acc) |=> osc_rdy_o);

  // R8
  reload_at_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_wrap |=> $stable(act_n));

  // R9
  irc_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |-> (ref_clk_o == irc_clk_i));

  // R10
  filt_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |-> (filt_rng_o == 2'b00));
endmodule

bind refdiv_top refdiv_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .we_i         (we_i),
  .prot_i       (prot_i),
  .pll_sel_i    (pll_sel_i),
  .lock_set_i   (lock_set_i),
  .osc_rdy_set_i(osc_rdy_set_i),
  .osc_en_i     (osc_en_i),
  .irc_clk_i    (irc_clk_i),
  .ref_clk_o    (ref_clk_o),
  .lock_o       (lock_o),
  .osc_rdy_o    (osc_rdy_o),
  .filt_rng_o   (filt_rng_o),
  .rdata_o      (rdata_o),
  .cfg_q        (cfg_q),
  .act_n        (act_n),
  .div_wrap     (div_wrap)
);

// File: tb/test_refdiv_top.sv
module test_refdiv_top;
  localparam int         CLK_PERIOD = 10;
  localparam logic [3:0] RA         = 4'h5;

  logic       clk_i = 1'b0, rst_ni = 1'b0, irc_clk_i = 1'b0;
  logic       osc_en_i = 1'b1, prot_i = 1'b0, pll_sel_i = 1'b1;
  logic [3:0] addr_i = RA;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       lock_set_i = 1'b0, osc_rdy_set_i = 1'b0;
  logic       lock_o, osc_rdy_o, ref_clk_o;
  logic [1:0] filt_rng_o;

  int n_chk = 0, n_fail = 0;

  typedef enum int {K_RDATA, K_LOCK, K_OSC, K_FILT, K_REF, K_IRC} kind_e;
  typedef struct {
    kind_e      kind;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];

  refdiv_top #(.ADDR_W(4), .REG_ADDR(RA)) i_refdiv_top (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  initial begin
    #23;
    forever #50 irc_clk_i = ~irc_clk_i;
  end

  task automatic cmp(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops expectations at each falling edge
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      case (it.kind)
        K_RDATA: cmp(it.req, "rdata",   rdata_o,             it.exp);
        K_LOCK:  cmp(it.req, "lock",    {7'b0, lock_o},      it.exp);
        K_OSC:   cmp(it.req, "osc_rdy", {7'b0, osc_rdy_o},   it.exp);
        K_FILT:  cmp(it.req, "filt",    {6'b0, filt_rng_o},  it.exp);
        K_REF:   cmp(it.req, "ref_clk", {7'b0, ref_clk_o},   it.exp);
        default: cmp(it.req, "ref_irc", {7'b0, ref_clk_o},   {7'b0, irc_clk_i});
      endcase
    end
  end

  task automatic push(kind_e k, logic [7:0] e, string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    sb_q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk_i); #1;
  endtask

  task automatic reg_write(logic [7:0] d, logic [3:0] a);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    step();
    we_i = 1'b0; addr_i = RA;
  endtask

  task automatic pulse_flags();
    lock_set_i = 1'b1; osc_rdy_set_i = 1'b1;
    step();
    lock_set_i = 1'b0; osc_rdy_set_i = 1'b0;
  endtask

  task automatic sync_rise();
    logic prev;
    prev = ref_clk_o;
    for (int i = 0; i < 64; i++) begin
      step();
      if (ref_clk_o && !prev) return;
      prev = ref_clk_o;
    end
    cmp("R6", "sync_timeout", 8'd1, 8'd0);
  endtask

  task automatic check_period(int p, int half, int cnt, string r);
    for (int k = 1; k <= cnt; k++) begin
      push(K_REF, {7'b0, ((k % p) < half)}, r);
      step();
    end
  endtask

  initial begin
    step(); step();
    // R1 reset state
    push(K_RDATA, 8'h0F, "R1"); push(K_LOCK, 0, "R1");
    push(K_OSC, 0, "R1"); push(K_FILT, 0, "R1");
    step();
    rst_ni = 1'b1;
    step();

    // R2 other address reads zero
    addr_i = 4'h3;
    push(K_RDATA, 8'h00, "R2");
    step();
    addr_i = RA;

    // R5 set pulses
    pulse_flags();
    push(K_LOCK, 1, "R5"); push(K_OSC, 1, "R5");
    step();

    // R3/R4 protected write ignored
    prot_i = 1'b1;
    reg_write(8'h25, RA);
    push(K_RDATA, 8'h0F, "R3"); push(K_LOCK, 1, "R4"); push(K_OSC, 1, "R4");
    step();
    prot_i = 1'b0;

    // R3/R4 write outside PLL-select mode ignored
    pll_sel_i = 1'b0;
    reg_write(8'h25, RA);
    push(K_RDATA, 8'h0F, "R3"); push(K_LOCK, 1, "R4");
    step();
    pll_sel_i = 1'b1;

    // R3 write to other address ignored
    reg_write(8'h25, 4'h2);
    push(K_RDATA, 8'h0F, "R3"); push(K_OSC, 1, "R4");
    step();

    // R2/R3/R4/R10 accepted write, reserved bits dropped
    reg_write(8'hE5, RA);
    push(K_RDATA, 8'h25, "R2"); push(K_LOCK, 0, "R4");
    push(K_OSC, 0, "R4"); push(K_FILT, 8'h02, "R10");
    step();

    // R9/R10 internal clock selected
    osc_en_i = 1'b0;
    #1;
    push(K_FILT, 8'h00, "R10"); push(K_RDATA, 8'h25, "R10");
    for (int i = 0; i < 24; i++) begin
      push(K_IRC, 0, "R9");
      step();
    end
    osc_en_i = 1'b1;
    step();

    // R5 clear wins over a same-cycle set
    pulse_flags();
    addr_i = RA; wdata_i = 8'h25; we_i = 1'b1;
    lock_set_i = 1'b1; osc_rdy_set_i = 1'b1;
    step();
    we_i = 1'b0; lock_set_i = 1'b0; osc_rdy_set_i = 1'b0;
    push(K_LOCK, 0, "R5"); push(K_OSC, 0, "R5");
    step();

    // R6 even ratio N=5: high 3, low 3
    sync_rise();
    check_period(6, 3, 12, "R6");

    // R6 odd ratio N=4: high 2, low 3
    reg_write(8'h04, RA);
    sync_rise();
    check_period(5, 2, 10, "R6");

    // R8 mid-period reprogram 7 -> 3
    reg_write(8'h07, RA);
    sync_rise();
    for (int k = 1; k <= 15; k++) begin
      if (k == 2) begin addr_i = RA; wdata_i = 8'h03; we_i = 1'b1; end
      if (k == 3) we_i = 1'b0;
      push(K_REF, {7'b0, (k < 8) ? (k < 4) : (((k - 8) % 4) < 2)}, "R8");
      step();
    end

    // R7 unity ratio passes the oscillator clock
    reg_write(8'h00, RA);
    for (int i = 0; i < 12; i++) step();
    push(K_REF, 0, "R7");
    step();
    @(posedge clk_i); #1;
    cmp("R7", "ref_clk_high", {7'b0, ref_clk_o}, 8'd1);
    step();

    // R10 remaining filter codes
    reg_write(8'h30, RA);
    push(K_FILT, 8'h03, "R10");
    step();
    reg_write(8'h10, RA);
    push(K_FILT, 8'h01, "R10");
    step();

    // R1 asynchronous reset, no clock edge
    pulse_flags();
    step();
    rst_ni = 1'b0;
    #1;
    cmp("R1", "rdata_async", rdata_o, 8'h0F);
    cmp("R1", "lock_async", {7'b0, lock_o}, 8'd0);
    cmp("R1", "osc_async", {7'b0, osc_rdy_o}, 8'd0);
    step();
    rst_ni = 1'b1;
    step();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule